// File: doc/BRIEF.md
# Indirect Stream Address Generator

This block produces the address sequence for one memory stream that a processor reads as if it were a register. In its plain mode it walks a fixed stride from a start address. In its gather mode it first reads a list of sparse indices from memory over a separate read-only port. Each 64-bit word that comes back holds several packed indices. The block unpacks them, scales each one to the byte offset of a 64-bit element, optionally widens that offset by an extra power-of-two stride, and adds a data base address. It then issues one element read per index on the data request port. The processor only has to issue the arithmetic that consumes the stream.

Software sets up a job by writing a small set of configuration registers and then writing the launch register. Index words are fetched ahead into a small buffer, so element requests can follow one another in consecutive cycles while the data port accepts them. When the configured number of element requests has been issued, `done` rises and stays high until the next launch.

Top module: `gag_top`

## Requirements
- R1: With gather mode off (mode register, `cfg_addr` 3, bit 0 = 0), element `i` of a job is requested at `data_base + i*stride`, in ascending `i`. `data_base` is at `cfg_addr` 1 and `stride` is at `cfg_addr` 4.
- R2: With gather mode on and narrow indices (mode bit 1 = 0), each 64-bit index word yields four 16-bit indices, taken from bits [15:0] upward. Each index becomes the address `data_base + (index << 3)` when the extra shift is 0.
- R3: With wide indices (mode bit 1 = 1), each index word yields two 32-bit indices, bits [31:0] first and then bits [63:32].
- R4: The extra shift in mode bits [7:4] is added to the fixed shift of 3, giving `data_base + (index << (3 + extra))`, truncated to 32 bits.
- R5: The index list starts at the byte address held at `cfg_addr` 0, which may be unaligned. The first word fetched is at that address rounded down to 8 bytes. Consumption of that word begins at lane `addr[2:1]` for narrow indices and at lane `addr[2]` for wide ones.
- R6: A job issues exactly as many element requests as the count held at `cfg_addr` 2. It fetches exactly ceil((first lane + count) / lanes per word) index words, and unused lanes of the last word are dropped. After the last request, `done` is high and `busy` is low.
- R7: While the data port withholds ready, `dat_req_valid` stays high and `dat_req_addr` stays unchanged. No index is lost or issued twice under any pattern of backpressure.
- R8: A launch with a count of zero issues no requests of either kind and raises `done` in the cycle after the launch write.
- R9: A write to the launch register (`cfg_addr` 5, any data) while `busy` is high has no effect on the running job.
- R10: Index word requests go to consecutive 8-byte addresses. Outstanding index fetches plus buffered words never exceed `FIFO_DEPTH`.
- R11: In stride mode with the data port always ready, one element request is accepted in every cycle from the first until the last.
- R12: After reset, no request is valid, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| idx_req_valid | output | 1 | Index word fetch request valid |
| idx_req_ready | input | 1 | Index port accepts the request |
| idx_req_addr | output | 32 | Byte address of the index word (8-byte aligned) |
| idx_rsp_valid | input | 1 | Index word returned (in request order) |
| idx_rsp_data | input | 64 | Returned index word |
| dat_req_valid | output | 1 | Element request valid |
| dat_req_ready | input | 1 | Data port accepts the element request |
| dat_req_addr | output | 32 | Element byte address |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished; cleared by the next launch |

## Verification
The bench targets unaligned list starts in both index widths. A design that got the start lane wrong would replay or skip the first indices of a job, and one that got the word count wrong would make one index fetch too many or too few. It runs jobs whose counts end in the middle of a word: a faulty design would either hang waiting for a word it never fetched or leave a stale word behind, and that stale word would corrupt the next job. Random backpressure on both ports exposes a design that advances its lane pointer on a stalled cycle, which would show up as duplicated or missing addresses. Launches with a count of zero, and launch writes made during a running job, expose a done flag that never rises and a job that restarts part way through.

// File: rtl/gag_pkg.sv
package gag_pkg;

  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 64;
  localparam int ELEM_SHIFT = 3;

  typedef enum logic [2:0] {
    REG_IDX_BASE = 3'd0,
    REG_DAT_BASE = 3'd1,
    REG_COUNT    = 3'd2,
    REG_MODE     = 3'd3,
    REG_STRIDE   = 3'd4,
    REG_LAUNCH   = 3'd5
  } cfg_reg_e;

  // lane where consumption starts inside the first index word
  function automatic logic [1:0] first_lane(logic [ADDR_W-1:0] a, logic wide);
    return wide ? {1'b0, a[2]} : a[2:1];
  endfunction

  // extract one index, lanes counted from the least significant end
  function automatic logic [31:0] pick_index(logic [WORD_W-1:0] w, logic [1:0] lane, logic wide);
    logic [WORD_W-1:0] sh;
    if (wide) begin
      sh = w >> {lane[0], 5'b0};
      return sh[31:0];
    end
    sh = w >> {lane, 4'b0};
    return {16'h0, sh[15:0]};
  endfunction

  // element byte address from an index
  function automatic logic [ADDR_W-1:0] scale_addr(logic [ADDR_W-1:0] base, logic [31:0] idx,
                                                   logic [3:0] xsh);
    return base + (idx << (ELEM_SHIFT + int'(xsh)));
  endfunction

  // number of index words a job touches
  function automatic logic [31:0] words_needed(logic [1:0] lane0, logic [31:0] cnt, logic wide);
    logic [31:0] total;
    if (cnt == 32'd0) return 32'd0;
    total = cnt + 32'(lane0);
    return wide ? ((total + 32'd1) >> 1) : ((total + 32'd3) >> 2);
  endfunction

endpackage

// File: rtl/gag_cfg.sv
module gag_cfg
  import gag_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int XSH_W = 4
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [2:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic                busy_i,
  output logic [ADDR_W-1:0]   idx_base_o,
  output logic [ADDR_W-1:0]   dat_base_o,
  output logic [ADDR_W-1:0]   stride_o,
  output logic [CNT_W-1:0]    count_o,
  output logic                gather_o,
  output logic                wide_o,
  output logic [XSH_W-1:0]    xshift_o,
  output logic                launch_o
);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_base_o <= '0;
      dat_base_o <= '0;
      stride_o   <= '0;
      count_o    <= '0;
      gather_o   <= 1'b0;
      wide_o     <= 1'b0;
      xshift_o   <= '0;
    end else if (we_i) begin
      case (cfg_reg_e'(addr_i))
        REG_IDX_BASE: idx_base_o <= wdata_i;
        REG_DAT_BASE: dat_base_o <= wdata_i;
        REG_STRIDE:   stride_o   <= wdata_i;
        REG_COUNT:    count_o    <= wdata_i[CNT_W-1:0];
        REG_MODE: begin
          gather_o <= wdata_i[0];
          wide_o   <= wdata_i[1];
          xshift_o <= wdata_i[4 +: XSH_W];
        end
        default: ;
      endcase
    end
  end

  // a launch during a running job is dropped
  assign launch_o = we_i && (cfg_reg_e'(addr_i) == REG_LAUNCH) && !busy_i;

endmodule

// File: rtl/gag_fetch.sv
module gag_fetch
  import gag_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic                gather_i,
  input  logic                wide_i,
  input  logic [ADDR_W-1:0]   idx_base_i,
  input  logic [CNT_W-1:0]    count_i,
  output logic                idx_req_valid_o,
  input  logic                idx_req_ready_i,
  output logic [ADDR_W-1:0]   idx_req_addr_o,
  input  logic                idx_rsp_valid_i,
  input  logic [WORD_W-1:0]   idx_rsp_data_i,
  output logic                head_valid_o,
  output logic [WORD_W-1:0]   head_data_o,
  input  logic                pop_i
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [CNT_W:0]      words_left;
  logic [ADDR_W-1:0]   req_addr;
  logic [CW-1:0]       inflight, fill;
  logic [PW-1:0]       wr_ptr, rd_ptr;
  logic [WORD_W-1:0]   buf_q [DEPTH];

  logic room, req_fire, push_ev, pop_ev;

  assign room            = (inflight + fill) < CW'(DEPTH);
  assign idx_req_valid_o = (words_left != '0) && room;
  assign idx_req_addr_o  = req_addr;
  assign req_fire        = idx_req_valid_o && idx_req_ready_i;
  assign push_ev         = idx_rsp_valid_i;
  assign pop_ev          = pop_i;
  assign head_valid_o    = fill != '0;
  assign head_data_o     = buf_q[rd_ptr];

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      words_left <= '0;
      req_addr   <= '0;
      inflight   <= '0;
      fill       <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
    end else begin
      if (launch_i) begin
        words_left <= gather_i
          ? (CNT_W+1)'(words_needed(first_lane(idx_base_i, wide_i), 32'(count_i), wide_i))
          : '0;
        req_addr   <= {idx_base_i[ADDR_W-1:3], 3'b000};
      end else if (req_fire) begin
        words_left <= words_left - 1'b1;
        req_addr   <= req_addr + ADDR_W'(8);
      end
      inflight <= inflight + CW'(req_fire) - CW'(push_ev);
      fill     <= fill + CW'(push_ev) - CW'(pop_ev);
      if (push_ev) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ev)  rd_ptr <= ptr_next(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ev) buf_q[wr_ptr] <= idx_rsp_data_i;
  end

  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_ni)
    (inflight + fill) <= CW'(DEPTH)); // R10
  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_ni)
    idx_rsp_valid_i |-> (inflight != '0)); // R10
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (idx_req_valid_o && !idx_req_ready_i) |=> (idx_req_valid_o && $stable(idx_req_addr_o))); // R10

endmodule

// File: rtl/gag_emit.sv
module gag_emit
  import gag_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int XSH_W = 4
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic                gather_i,
  input  logic                wide_i,
  input  logic [XSH_W-1:0]    xshift_i,
  input  logic [ADDR_W-1:0]   idx_base_i,
  input  logic [ADDR_W-1:0]   dat_base_i,
  input  logic [ADDR_W-1:0]   stride_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic                head_valid_i,
  input  logic [WORD_W-1:0]   head_data_i,
  output logic                pop_o,
  output logic                dat_req_valid_o,
  input  logic                dat_req_ready_i,
  output logic [ADDR_W-1:0]   dat_req_addr_o,
  output logic                busy_o,
  output logic                done_o
);

  logic [CNT_W-1:0]   left;
  logic [1:0]         lane;
  logic [ADDR_W-1:0]  walk_addr, base_q, stride_q;
  logic               gather_q, wide_q;
  logic [XSH_W-1:0]   xsh_q;
  logic               busy_q, done_q;

  logic               elem_fire, lane_last, job_last;
  logic [31:0]        cur_index;

  assign cur_index       = pick_index(head_data_i, lane, wide_q);
  assign dat_req_valid_o = busy_q && (!gather_q || head_valid_i);
  assign dat_req_addr_o  = gather_q ? scale_addr(base_q, cur_index, 4'(xsh_q)) : walk_addr;
  assign elem_fire       = dat_req_valid_o && dat_req_ready_i;
  assign lane_last       = wide_q ? lane[0] : (lane == 2'd3);
  assign job_last        = left == CNT_W'(1);
  assign pop_o           = elem_fire && gather_q && (lane_last || job_last);
  assign busy_o          = busy_q;
  assign done_o          = done_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      left      <= '0;
      lane      <= '0;
      walk_addr <= '0;
      base_q    <= '0;
      stride_q  <= '0;
      gather_q  <= 1'b0;
      wide_q    <= 1'b0;
      xsh_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else if (launch_i) begin
      left      <= count_i;
      lane      <= first_lane(idx_base_i, wide_i);
      walk_addr <= dat_base_i;
      base_q    <= dat_base_i;
      stride_q  <= stride_i;
      gather_q  <= gather_i;
      wide_q    <= wide_i;
      xsh_q     <= xshift_i;
      busy_q    <= count_i != '0;
      done_q    <= count_i == '0;
    end else if (elem_fire) begin
      left      <= left - 1'b1;
      walk_addr <= walk_addr + stride_q;
      lane      <= lane_last ? 2'd0 : lane + 2'd1;
      if (job_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (dat_req_valid_o && !dat_req_ready_i) |=> (dat_req_valid_o && $stable(dat_req_addr_o))); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> !dat_req_valid_o); // R6
  AST_POP_SAFE: assert property (@(posedge clk) disable iff (!rst_ni)
    pop_o |-> head_valid_i); // R2
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(busy_o && done_o)); // R6

endmodule

// File: rtl/gag_top.sv
module gag_top
  import gag_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int XSH_W      = 4,
  parameter int FIFO_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_addr,
  input  logic [31:0]  cfg_wdata,
  output logic         idx_req_valid,
  input  logic         idx_req_ready,
  output logic [31:0]  idx_req_addr,
  input  logic         idx_rsp_valid,
  input  logic [63:0]  idx_rsp_data,
  output logic         dat_req_valid,
  input  logic         dat_req_ready,
  output logic [31:0]  dat_req_addr,
  output logic         busy,
  output logic         done
);

  logic [ADDR_W-1:0] idx_base, dat_base, stride;
  logic [CNT_W-1:0]  count;
  logic              gather, wide, launch;
  logic [XSH_W-1:0]  xshift;
  logic              head_valid, pop;
  logic [WORD_W-1:0] head_data;

  gag_cfg #(.CNT_W(CNT_W), .XSH_W(XSH_W)) u_cfg (
    .clk, .rst_ni,
    .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata), .busy_i(busy),
    .idx_base_o(idx_base), .dat_base_o(dat_base), .stride_o(stride),
    .count_o(count), .gather_o(gather), .wide_o(wide), .xshift_o(xshift),
    .launch_o(launch)
  );

  gag_fetch #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fetch (
    .clk, .rst_ni,
    .launch_i(launch), .gather_i(gather), .wide_i(wide),
    .idx_base_i(idx_base), .count_i(count),
    .idx_req_valid_o(idx_req_valid), .idx_req_ready_i(idx_req_ready),
    .idx_req_addr_o(idx_req_addr),
    .idx_rsp_valid_i(idx_rsp_valid), .idx_rsp_data_i(idx_rsp_data),
    .head_valid_o(head_valid), .head_data_o(head_data), .pop_i(pop)
  );

  gag_emit #(.CNT_W(CNT_W), .XSH_W(XSH_W)) u_emit (
    .clk, .rst_ni,
    .launch_i(launch), .gather_i(gather), .wide_i(wide), .xshift_i(xshift),
    .idx_base_i(idx_base), .dat_base_i(dat_base), .stride_i(stride), .count_i(count),
    .head_valid_i(head_valid), .head_data_i(head_data), .pop_o(pop),
    .dat_req_valid_o(dat_req_valid), .dat_req_ready_i(dat_req_ready),
    .dat_req_addr_o(dat_req_addr),
    .busy_o(busy), .done_o(done)
  );

  AST_LAUNCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && cfg_we && cfg_addr == 3'd5) |=> !done); // R9

endmodule

// File: tb/tb_gag_top.sv
module tb_gag_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 2;
  localparam int RSP_LAT    = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        idx_req_valid, idx_req_ready = 1'b0;
  logic [31:0] idx_req_addr;
  logic        idx_rsp_valid = 1'b0;
  logic [63:0] idx_rsp_data = '0;
  logic        dat_req_valid, dat_req_ready = 1'b0;
  logic [31:0] dat_req_addr;
  logic        busy, done;

  gag_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int dat_pct = 100, idx_pct = 100;
  logic [63:0] imem [64];

  logic [31:0] rec_addr [256];
  int          rec_cyc  [256];
  int          rec_n = 0;
  int          fetch_n = 0;
  bit          seq_bad = 0;
  logic [31:0] fetch_expect = '0;
  logic [31:0] pq_addr [$];
  int          pq_time [$];
  int          max_pend = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // data port model
  initial forever begin
    @(negedge clk);
    dat_req_ready = ($urandom % 100) < dat_pct;
    #1;
    if (dat_req_valid && dat_req_ready && rec_n < 256) begin
      rec_addr[rec_n] = dat_req_addr;
      rec_cyc[rec_n]  = cyc;
      rec_n++;
    end
  end

  // index port model: in-order responses after a fixed latency
  initial forever begin
    @(negedge clk);
    idx_rsp_valid = 1'b0;
    if (pq_addr.size() > 0 && cyc >= pq_time[0]) begin
      idx_rsp_valid = 1'b1;
      idx_rsp_data  = imem[pq_addr[0][8:3]];
      void'(pq_addr.pop_front());
      void'(pq_time.pop_front());
    end
    idx_req_ready = ($urandom % 100) < idx_pct;
    #1;
    if (idx_req_valid && idx_req_ready) begin
      if (idx_req_addr != fetch_expect) seq_bad = 1;
      fetch_expect = idx_req_addr + 32'd8;
      fetch_n++;
      pq_addr.push_back(idx_req_addr);
      pq_time.push_back(cyc + RSP_LAT);
      if (pq_addr.size() > max_pend) max_pend = pq_addr.size();
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [31:0] want_addr(logic [31:0] ib, logic [31:0] db, int e, bit g,
                                            bit wd, int xs, logic [31:0] st);
    int per, start, pos;
    logic [63:0] word;
    logic [31:0] ix;
    if (!g) return db + st * e;
    per   = wd ? 2 : 4;
    start = wd ? int'(ib[2]) : int'(ib[2:1]);
    pos   = start + e;
    word  = imem[((ib >> 3) + pos / per) % 64];
    if (wd) ix = 32'(word >> (32 * (pos % per)));
    else    ix = {16'h0, 16'(word >> (16 * (pos % per)))};
    return db + (ix << (3 + xs));
  endfunction

  function automatic int want_words(logic [31:0] ib, int n, bit wd);
    int per, start;
    if (n == 0) return 0;
    per   = wd ? 2 : 4;
    start = wd ? int'(ib[2]) : int'(ib[2:1]);
    return (start + n + per - 1) / per;
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_job(input string tag, input logic [31:0] ib, input logic [31:0] db, input int n,
                         input bit g, input bit wd, input int xs, input logic [31:0] st,
                         input bit poke, input bit tput);
    int bad, waited;
    cfg_write(3'd0, ib);
    cfg_write(3'd1, db);
    cfg_write(3'd2, n);
    cfg_write(3'd3, {24'h0, 4'(xs), 2'b00, wd, g});
    cfg_write(3'd4, st);
    rec_n = 0; fetch_n = 0; seq_bad = 0; max_pend = 0;
    fetch_expect = {ib[31:3], 3'b000};
    cfg_write(3'd5, 32'h1);
    if (poke) begin
      repeat (3) @(negedge clk);
      cfg_write(3'd5, 32'h1);   // R9: launch while busy
    end
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    repeat (4) @(negedge clk);
    check(rec_n == n, {tag, " R6 element count"}, rec_n, n);
    bad = -1;
    for (int e = 0; e < rec_n && e < n; e++)
      if (bad < 0 && rec_addr[e] !== want_addr(ib, db, e, g, wd, xs, st)) bad = e;
    if (bad >= 0)
      check(0, {tag, " address"}, rec_addr[bad], want_addr(ib, db, bad, g, wd, xs, st));
    else
      check(1, tag, 0, 0);
    check(fetch_n == want_words(ib, n, wd && g) * int'(g), {tag, " R6 index words"},
          fetch_n, want_words(ib, n, wd && g) * int'(g));
    check(!seq_bad && max_pend <= DEPTH, {tag, " R10 fetch order/credit"}, max_pend, DEPTH);
    check(done && !busy, {tag, " R6 done/busy"}, {done, busy}, 2'b10);
    if (tput && n > 0)
      check(rec_cyc[n-1] - rec_cyc[0] == n - 1, {tag, " R11 back-to-back"},
            rec_cyc[n-1] - rec_cyc[0], n - 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) imem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    check(!dat_req_valid && !idx_req_valid && !busy && !done, "R12 reset idle",
          {dat_req_valid, idx_req_valid, busy, done}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!dat_req_valid && !idx_req_valid && !busy && !done, "R12 after release",
          {dat_req_valid, idx_req_valid, busy, done}, 0);

    dat_pct = 100; idx_pct = 100;
    run_job("R1 stride", 32'h0, 32'h1000, 20, 0, 0, 0, 32'h18, 0, 1);   // R11
    run_job("R2 narrow", 32'h40, 32'h8000, 12, 1, 0, 0, 0, 0, 0);
    run_job("R3 wide",   32'h80, 32'h4000, 9, 1, 1, 0, 0, 0, 0);
    run_job("R4 shift",  32'h10, 32'h200, 7, 1, 0, 5, 0, 0, 0);
    run_job("R5 narrow lane3", 32'h26, 32'h0, 6, 1, 0, 0, 0, 0, 0);
    run_job("R5 wide lane1",   32'h5C, 32'h100, 4, 1, 1, 2, 0, 0, 0);
    run_job("R6 ends mid word", 32'h8, 32'h0, 5, 1, 0, 0, 0, 0, 0);
    run_job("R8 zero count", 32'h6, 32'h0, 0, 1, 0, 0, 0, 0, 0);
    dat_pct = 30;
    run_job("R9 launch while busy", 32'h30, 32'h600, 10, 1, 0, 1, 0, 1, 0);
    run_job("R7 stalled stride", 32'h0, 32'h40, 8, 0, 0, 0, 32'hFFFF_FFF8, 0, 0);

    for (int j = 0; j < 14; j++) begin
      dat_pct = 40 + ($urandom % 61);
      idx_pct = 40 + ($urandom % 61);
      run_job("R7 random", $urandom % 256, $urandom, 1 + ($urandom % 40), $urandom % 2,
              $urandom % 2, $urandom % 8, $urandom % 64, 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule